// File: doc/BRIEF.md
# Retriggerable Resettable Digital One-Shot

This block is a clock-synchronous monostable. A trigger edge starts an output pulse whose length is a programmable number of clock cycles. An internal down-counter sets that length. Two trigger inputs are provided. One fires on a rising edge while the other input is HIGH. The other fires on a falling edge while the first input is LOW. An active-low clear input ends a pulse at once and holds the block idle. A lockout input chooses between two behaviours when a trigger arrives during a pulse: the pulse either restarts its full interval, or the trigger is ignored.

The trigger and clear inputs may be asynchronous. Each one passes through a two-flop synchronizer before any edge is detected. Because all three share the same latency, events that are coincident at the pins stay coincident inside the block. The width and lockout inputs are treated as synchronous. The width is captured when a pulse starts or restarts. The true and complementary outputs are both registered. A dual one-shot is built from two instances.

Top module: `oneshot_pulse_gen`

## Requirements
- R1: After reset, `q_o` is 0 and `q_n_o` is 1.
- R2: A 0-to-1 change on `trig_rise_i` while `trig_fall_i` is 1 starts a pulse. When the input changes between two rising clock edges, `q_o` is 1 after the third following rising edge.
- R3: A 0-to-1 change on `trig_rise_i` while `trig_fall_i` is 0 starts no pulse.
- R4: A 1-to-0 change on `trig_fall_i` while `trig_rise_i` is 0 starts a pulse with the same latency as R2. The same change while `trig_rise_i` is 1 starts no pulse.
- R5: A pulse lasts exactly the number of clock cycles on `width_i` at the cycle it starts. Later changes of `width_i` do not alter it. When it ends, `q_o` returns to 0 and `q_n_o` to 1.
- R6: With `lockout_i` = 0, a qualified trigger during a pulse reloads the full width without a gap, so the pulse is extended.
- R7: With `lockout_i` = 1, triggers during a pulse are ignored and the pulse ends after exactly one interval.
- R8: A 1-to-0 change on `clr_n_i` ends an active pulse. `q_o` is 0 after the third rising edge following the change.
- R9: While `clr_n_i` is held 0, trigger edges start no pulse. No pulse appears once the clear is released.
- R10: A clear falling in the same cycle as a qualified trigger edge wins, and no pulse is produced.
- R11: A clear rising in the same cycle as a qualified trigger edge lets the trigger start a pulse.
- R12: A trigger while `width_i` is 0 neither starts a pulse nor restarts a running one.
- R13: `q_o` is always the inverse of `q_n_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| trig_rise_i | input | 1 | Trigger input that acts on a rising edge; asynchronous |
| trig_fall_i | input | 1 | Trigger input that acts on a falling edge; asynchronous |
| clr_n_i | input | 1 | Active-low clear; asynchronous |
| lockout_i | input | 1 | 1 = triggers during a pulse are ignored; 0 = retriggerable |
| width_i | input | WIDTH_BITS | Pulse length in clock cycles; 0 means no pulse |
| q_o | output | 1 | Pulse output, active high |
| q_n_o | output | 1 | Complement of `q_o` |

## Verification
Each trigger input is driven once with the other input at its enabling level and once with it at its blocking level. This separates correct cross-qualification from plain edge detection.

A retrigger placed halfway through a pulse is run in both lockout settings. A ten-cycle result versus a six-cycle result shows whether the counter reloads or holds.

Clear is driven in several timings:
- before a trigger;
- in the same cycle as a trigger;
- released in the same cycle as a trigger;
- in the middle of a pulse.

Together these show the priority order, not only the fact that clear works.

A width change during a pulse and a zero-width retrigger show that the width is captured only when a pulse is accepted.

// File: rtl/oneshot_pkg.sv
`timescale 1ns/1ps
package oneshot_pkg;

  typedef struct packed {
    logic rise_hit;
    logic fall_hit;
  } trig_hits_t;

  // rising edge on one input, enabled while the partner input is high
  function automatic logic rise_qualified(logic now, logic prev, logic partner);
    return now & ~prev & partner;
  endfunction

  // falling edge on one input, enabled while the partner input is low
  function automatic logic fall_qualified(logic now, logic prev, logic partner);
    return ~now & prev & ~partner;
  endfunction

  // a hit is accepted unless cleared, zero width, or locked out while busy
  function automatic logic may_fire(logic hit, logic clr_hold, logic busy,
                                    logic lockout, logic width_nz);
    return hit & ~clr_hold & width_nz & (~busy | ~lockout);
  endfunction

endpackage

// File: rtl/os_sync.sv
`timescale 1ns/1ps
module os_sync #(
  parameter int         N       = 3,
  parameter int         STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[LAST-1:0], d[b]};
    end
    assign q[b] = chain[LAST];
  end
endmodule

// File: rtl/os_edge_qual.sv
`timescale 1ns/1ps
module os_edge_qual
  import oneshot_pkg::*;
#(
  parameter logic RISE_IDLE = 1'b0,
  parameter logic FALL_IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_s,
  input  logic fall_s,
  input  logic clr_n_s,
  input  logic busy,
  input  logic lockout,
  input  logic width_nz,
  output logic trig_hit,
  output logic clr_hold,
  output logic fire
);
  logic       rise_d, fall_d;
  trig_hits_t hits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_d <= RISE_IDLE;
      fall_d <= FALL_IDLE;
    end else begin
      rise_d <= rise_s;
      fall_d <= fall_s;
    end
  end

  assign hits.rise_hit = rise_qualified(rise_s, rise_d, fall_s);
  assign hits.fall_hit = fall_qualified(fall_s, fall_d, rise_s);
  assign trig_hit      = |hits;
  assign clr_hold      = ~clr_n_s;
  assign fire          = may_fire(trig_hit, clr_hold, busy, lockout, width_nz);
endmodule

// File: rtl/os_timer.sv
`timescale 1ns/1ps
module os_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic         clr_hold,
  input  logic [W-1:0] width,
  output logic [W-1:0] rem,
  output logic         busy,
  output logic         q,
  output logic         qn
);
  localparam logic [W-1:0] ZERO = '0;

  // cycles left including the current one
  function automatic logic [W-1:0] next_rem(logic [W-1:0] cur, logic [W-1:0] load,
                                            logic ld, logic kill);
    if (kill)        return ZERO;
    if (ld)          return load;
    if (cur != ZERO) return cur - 1'b1;
    return ZERO;
  endfunction

  logic [W-1:0] rem_q, rem_nx;

  assign rem_nx = next_rem(rem_q, width, fire, clr_hold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= ZERO;
      q     <= 1'b0;
      qn    <= 1'b1;
    end else begin
      rem_q <= rem_nx;
      q     <= (rem_nx != ZERO);
      qn    <= (rem_nx == ZERO);
    end
  end

  assign rem  = rem_q;
  assign busy = (rem_q != ZERO);
endmodule

// File: rtl/oneshot_pulse_gen.sv
`timescale 1ns/1ps
module oneshot_pulse_gen #(
  parameter int WIDTH_BITS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trig_rise_i,
  input  logic                  trig_fall_i,
  input  logic                  clr_n_i,
  input  logic                  lockout_i,
  input  logic [WIDTH_BITS-1:0] width_i,
  output logic                  q_o,
  output logic                  q_n_o
);
  localparam logic [2:0] SYNC_IDLE = 3'b110; // {clr_n, fall, rise}

  logic [2:0]            sync_q;
  logic                  rise_s, fall_s, clr_n_s;
  logic                  trig_hit, clr_hold, fire, busy;
  logic [WIDTH_BITS-1:0] rem;

  os_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_IDLE)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d ({clr_n_i, trig_fall_i, trig_rise_i}),
    .q (sync_q)
  );

  assign rise_s  = sync_q[0];
  assign fall_s  = sync_q[1];
  assign clr_n_s = sync_q[2];

  os_edge_qual #(.RISE_IDLE(SYNC_IDLE[0]), .FALL_IDLE(SYNC_IDLE[1])) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_s   (rise_s),
    .fall_s   (fall_s),
    .clr_n_s  (clr_n_s),
    .busy     (busy),
    .lockout  (lockout_i),
    .width_nz (|width_i),
    .trig_hit (trig_hit),
    .clr_hold (clr_hold),
    .fire     (fire)
  );

  os_timer #(.W(WIDTH_BITS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .clr_hold (clr_hold),
    .width    (width_i),
    .rem      (rem),
    .busy     (busy),
    .q        (q_o),
    .qn       (q_n_o)
  );
endmodule

// File: rtl/os_chk.sv
`timescale 1ns/1ps
module os_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         q,
  input logic         qn,
  input logic         fire,
  input logic         trig_hit,
  input logic         clr_hold,
  input logic         lockout,
  input logic [W-1:0] width,
  input logic [W-1:0] rem
);
  // R13
  comp_chk: assert property (@(posedge clk) disable iff (!rst_n) q == ~qn);

  // R2
  fire_q_chk: assert property (@(posedge clk) disable iff (!rst_n) fire |=> q);

  // R8
  clr_kill_chk: assert property (@(posedge clk) disable iff (!rst_n) clr_hold |=> !q);

  // R9
  clr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hold && !q) |=> !q);

  // R7
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lockout && q && !clr_hold) |=> (rem == $past(rem) - 1'b1));

  // R6
  retrig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lockout && trig_hit && !clr_hold && width != '0) |=> (rem == $past(width)));

  // R5
  end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q) |-> ($past(clr_hold) || $past(rem) == 1));
endmodule

bind oneshot_pulse_gen os_chk #(.W(WIDTH_BITS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .q        (q_o),
  .qn       (q_n_o),
  .fire     (fire),
  .trig_hit (trig_hit),
  .clr_hold (clr_hold),
  .lockout  (lockout_i),
  .width    (width_i),
  .rem      (rem)
);

// File: tb/sim_oneshot_pulse_gen.sv
`timescale 1ns/1ps
module sim_oneshot_pulse_gen;
  localparam int WB = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rise = 1'b0, fall = 1'b1, clr_n = 1'b1, lock = 1'b0;
  logic [WB-1:0] width = 8'd5;
  logic          q, qn;

  int checks = 0, fails = 0;
  int highs, first, last, cmp_err;

  typedef struct { int at; int sig; int val; } ev_t; // sig: 0 rise 1 fall 2 clr_n 3 width 4 lock
  ev_t evs[6];
  int  nev;

  always #2 clk = ~clk; // 250 MHz

  oneshot_pulse_gen #(.WIDTH_BITS(WB)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_rise_i(rise), .trig_fall_i(fall),
    .clr_n_i(clr_n), .lockout_i(lock), .width_i(width), .q_o(q), .q_n_o(qn)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_ev(); nev = 0; endtask
  task automatic add_ev(int at, int sig, int val);
    evs[nev].at = at; evs[nev].sig = sig; evs[nev].val = val; nev++;
  endtask

  task automatic apply(int idx);
    for (int k = 0; k < nev; k++) begin
      if (evs[k].at == idx) begin
        case (evs[k].sig)
          0: rise  = evs[k].val[0];
          1: fall  = evs[k].val[0];
          2: clr_n = evs[k].val[0];
          3: width = evs[k].val[WB-1:0];
          default: lock = evs[k].val[0];
        endcase
      end
    end
  endtask

  // index 0 drives at a falling edge; sample i is taken i falling edges later
  task automatic run_window(int n);
    highs = 0; first = 0; last = 0; cmp_err = 0;
    @(negedge clk); apply(0);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (q !== ~qn) cmp_err++;
      if (q === 1'b1) begin
        highs++;
        if (first == 0) first = i;
        last = i;
      end
      apply(i);
    end
  endtask

  task automatic t_reset();
    check("R1 q after reset", q, 0);
    check("R1 q_n after reset", qn, 1);
  endtask

  task automatic t_rise_ok();
    width = 8'd5;
    clr_ev(); add_ev(0, 0, 1); add_ev(6, 0, 0);
    run_window(20);
    check("R2 rise latency", first, 3);
    check("R5 rise width", highs, 5);
    check("R13 complement", cmp_err, 0);
  endtask

  task automatic t_rise_blocked();
    clr_ev(); add_ev(0, 3, 0); add_ev(0, 1, 0); add_ev(4, 3, 5); add_ev(6, 0, 1);
    run_window(20);
    check("R3 rise with fall low", highs, 0);
  endtask

  task automatic t_fall_blocked();
    // state: rise=1 fall=0
    clr_ev(); add_ev(0, 3, 0); add_ev(0, 1, 1); add_ev(4, 3, 5); add_ev(6, 1, 0);
    add_ev(10, 0, 0); add_ev(12, 1, 1);
    run_window(25);
    check("R4 fall with rise high", highs, 0);
  endtask

  task automatic t_fall_ok();
    clr_ev(); add_ev(0, 1, 0); add_ev(6, 1, 1);
    run_window(20);
    check("R4 fall latency", first, 3);
    check("R4 fall width", highs, 5);
  endtask

  task automatic t_width_latch();
    clr_ev(); add_ev(0, 3, 9); add_ev(0, 0, 1); add_ev(2, 0, 0); add_ev(5, 3, 2);
    run_window(25);
    check("R5 width latched", highs, 9);
    check("R5 end cycle", last, 11);
    check("R5 q_n after end", qn, 1);
    width = 8'd6;
  endtask

  task automatic t_retrig();
    lock = 1'b0;
    clr_ev(); add_ev(0, 0, 1); add_ev(2, 0, 0); add_ev(4, 0, 1); add_ev(8, 0, 0);
    run_window(25);
    check("R6 extended length", highs, 10);
    check("R6 extended end", last, 12);
    check("R13 complement retrig", cmp_err, 0);
  endtask

  task automatic t_lockout();
    lock = 1'b1;
    clr_ev(); add_ev(0, 0, 1); add_ev(2, 0, 0); add_ev(4, 0, 1); add_ev(8, 0, 0);
    run_window(25);
    check("R7 lockout length", highs, 6);
    check("R7 lockout end", last, 8);
    lock = 1'b0;
  endtask

  task automatic t_clear_mid();
    width = 8'd10;
    clr_ev(); add_ev(0, 0, 1); add_ev(3, 0, 0); add_ev(5, 2, 0); add_ev(15, 2, 1);
    run_window(25);
    check("R8 clear cuts pulse", highs, 5);
    check("R8 clear cut cycle", last, 7);
  endtask

  task automatic t_clear_hold();
    width = 8'd4;
    clr_ev(); add_ev(0, 2, 0); add_ev(3, 0, 1); add_ev(12, 2, 1); add_ev(20, 0, 0);
    run_window(30);
    check("R9 no pulse under clear", highs, 0);
  endtask

  task automatic t_clear_coincide_fall();
    clr_ev(); add_ev(0, 2, 0); add_ev(0, 0, 1); add_ev(10, 2, 1); add_ev(14, 0, 0);
    run_window(22);
    check("R10 clear beats trigger", highs, 0);
  endtask

  task automatic t_clear_coincide_rise();
    clr_ev(); add_ev(0, 2, 0); add_ev(5, 2, 1); add_ev(5, 0, 1); add_ev(10, 0, 0);
    run_window(22);
    check("R11 trigger on release start", first, 8);
    check("R11 trigger on release width", highs, 4);
  endtask

  task automatic t_zero_width();
    clr_ev(); add_ev(0, 3, 0); add_ev(0, 0, 1); add_ev(4, 0, 0);
    run_window(15);
    check("R12 zero width no pulse", highs, 0);
    clr_ev(); add_ev(0, 3, 6); add_ev(0, 0, 1); add_ev(2, 0, 0); add_ev(3, 3, 0);
    add_ev(4, 0, 1); add_ev(8, 0, 0);
    run_window(22);
    check("R12 zero width no restart", highs, 6);
    width = 8'd5;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rise_ok();
    t_rise_blocked();
    t_fall_blocked();
    t_fall_ok();
    t_width_latch();
    t_retrig();
    t_lockout();
    t_clear_mid();
    t_clear_hold();
    t_clear_coincide_fall();
    t_clear_coincide_rise();
    t_zero_width();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule